// File: doc/BRIEF.md
# Set-Associative Load-Path Cache with Victim Castout

This block is a data cache controller for the processor load and store path. It is eight-way set associative, holds 32-byte lines and has a default capacity of 32 kB in 128 sets. It accepts one doubleword request at a time. One cycle after a request is accepted, it reports whether the addressed line is resident. A read hit returns its doubleword in that same cycle.

On a miss, the block asks the next level for the whole aligned line. The line arrives as four sequential 64-bit beats. The requester gets its doubleword one cycle after the beat that holds it has been written. When the block allocates the line, it picks a way in the indexed set. An empty way is always taken first. In a full set, a pseudo-LRU tree picks the way. The line that was in that way leaves on a castout port toward the next level, together with its address and its modified flag. A configuration input sets the caching policy:
- With `lastLevel` low, every displaced line is forwarded. The next level then fills only from these victims.
- With `lastLevel` high, only modified lines are written back and clean lines are discarded.

Stores allocate on a miss and set the line's modified bit.

Top module: `victim_cache`

## Requirements
- R1: A synchronous reset invalidates every line and clears all modified and replacement state. After reset, `reqReady` is high, the first access to any address misses, and such a miss raises no castout.
- R2: `lookupValid` pulses exactly one cycle after a request is accepted (`reqValid` and `reqReady` both high at a clock edge). In that cycle, `lookupHit` tells whether the addressed line is resident.
- R3: On a read hit, `rspValid` is high and `rspData` carries the addressed doubleword in the same cycle as `lookupValid`.
- R4: On a miss, `fillReq` pulses in the `lookupValid` cycle, and `fillAddr` is the line-aligned byte address (low 5 bits zero). The line is then taken as four beats, in order 0 to 3. Beat k carries bytes 8k to 8k+7 of the line, and a beat is consumed on each cycle that `fillBeatValid` is high.
- R5: For a miss, `rspValid` is high exactly in the cycle after the beat holding the requested doubleword is consumed, and low during the other beats. That beat is byte-address bits [4:3], which are `reqDwAddr` bits [1:0]. `rspData` then holds that doubleword.
- R6: A store hit overwrites the addressed doubleword and marks the line modified. A store miss allocates the line and places the store data in place of the matching fill beat. The remaining doublewords come from the fill.
- R7: The set index is byte-address bits [11:5], so addresses a multiple of 4 kB apart share one set. Eight such lines can be resident together.
- R8: An invalid way in the indexed set is always allocated before any valid way is evicted. No castout occurs while the set still holds an invalid way.
- R9: Each set keeps a 7-bit pseudo-LRU tree. Each node bit chooses which half of its subtree holds the victim: 0 picks the lower-numbered half and 1 the upper half. Every hit and every completed fill sets the bits on the accessed way's path to point away from that way.
- R10: When a valid line is evicted, `castValid` pulses in the miss cycle with the victim's address, full data and modified flag. A modified victim is always sent. A clean victim is sent when `lastLevel` is 0 and dropped (no `castValid`) when `lastLevel` is 1.
- R11: `reqReady` stays low from the accepting edge until the lookup or fill has finished and its response has been presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lastLevel | input | 1 | 1: drop clean victims; 0: forward all victims |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqDwAddr | input | 29 | Doubleword address (byte address / 8) |
| reqWdata | input | 64 | Store data |
| lookupValid | output | 1 | Lookup result valid (one cycle after accept) |
| lookupHit | output | 1 | Line was resident |
| rspValid | output | 1 | Read data valid |
| rspData | output | 64 | Requested doubleword |
| fillReq | output | 1 | Line fill request pulse |
| fillAddr | output | 32 | Line-aligned byte address to fetch |
| fillBeatValid | input | 1 | Fill beat present |
| fillBeatData | input | 64 | Fill beat data |
| castValid | output | 1 | Victim line presented |
| castDirty | output | 1 | Victim was modified |
| castAddr | output | 32 | Victim line byte address |
| castData | output | 256 | Victim line contents |

## Verification
Corrupted tag or valid state shows up at the very next lookup of that set. The `lookupHit` flag and the `fillReq` pulse then disagree with the expected residency one cycle after the request. A wrong replacement tree produces no symptom until the set is full. After that, the first eviction names the wrong line on `castAddr` in its miss cycle. Merge or beat-placement errors show in `rspData` only when the affected doubleword is read, or in `castData` once the line is evicted. For that reason the tests re-read lines after stores and check whole victim lines.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } vcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch incoming request
    logic touchHit;   // hit: update tree, apply store
    logic allocate;   // miss: claim victim way, write tag
    logic beatWrite;  // write one fill beat into the line
    logic complete;   // last beat: mark valid, update tree
  } vcStrobe_t;

endpackage

// File: rtl/vc_plru.sv
module vc_plru #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-2:0]         treeIn,
  input  logic [$clog2(WAYS)-1:0] touchWay,
  output logic [WAYS-2:0]         treeOut,
  output logic [$clog2(WAYS)-1:0] victimWay
);
  localparam int WAY_W = $clog2(WAYS);

  int unsigned node;
  logic        dir;

  // path update: each node on the path points away from touchWay
  always_comb begin
    treeOut = treeIn;
    node    = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      dir = touchWay[WAY_W-1-lvl];
      treeOut[node[WAY_W-1:0]] = ~dir;
      node = 2 * node + 1 + 32'(dir);
    end
  end

  int unsigned vNode;
  logic        vDir;

  // victim walk: follow node bits from the root
  always_comb begin
    victimWay = '0;
    vNode     = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      vDir = treeIn[vNode[WAY_W-1:0]];
      victimWay[WAY_W-1-lvl] = vDir;
      vNode = 2 * vNode + 1 + 32'(vDir);
    end
  end

endmodule

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_W     = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  vcStrobe_t                            strobe,
  input  logic [$clog2(LINE_BYTES*8/BEAT_W)-1:0] beatIdx,
  input  logic [ADDR_W-$clog2(BEAT_W/8)-1:0]   reqDwAddr,
  input  logic                                 reqWrite,
  input  logic [BEAT_W-1:0]                    reqWdata,
  input  logic [BEAT_W-1:0]                    fillBeatData,
  output logic                                 hit,
  output logic                                 critBeat,
  output logic                                 victimValid,
  output logic                                 victimDirty,
  output logic [ADDR_W-1:0]                    victimAddr,
  output logic [LINE_BYTES*8-1:0]              victimData,
  output logic [ADDR_W-1:0]                    fillAddr,
  output logic [BEAT_W-1:0]                    rdData
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BEATS  = LINE_W / BEAT_W;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int DW_OFF = $clog2(BEAT_W / 8);
  localparam int BSEL_W = $clog2(BEATS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int DWA_W  = ADDR_W - DW_OFF;
  localparam int TAG_W  = DWA_W - BSEL_W - IDX_W;
  localparam int SH_W   = $clog2(BEAT_W);
  localparam int SEL_W  = $clog2(LINE_W);
  localparam int SLOTS  = SETS * WAYS;

  // captured request
  logic [DWA_W-1:0]  pDw;
  logic              pWrite;
  logic [BEAT_W-1:0] pWdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      pDw    <= '0;
      pWrite <= 1'b0;
      pWdata <= '0;
    end else if (strobe.capture) begin
      pDw    <= reqDwAddr;
      pWrite <= reqWrite;
      pWdata <= reqWdata;
    end
  end

  logic [BSEL_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  assign word = pDw[BSEL_W-1:0];
  assign idx  = pDw[BSEL_W +: IDX_W];
  assign tag  = pDw[DWA_W-1 -: TAG_W];

  // storage
  logic [TAG_W-1:0]  tagMem  [SLOTS];
  logic [LINE_W-1:0] dataMem [SLOTS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [WAYS-1:0]   dirtyArr [SETS];
  logic [WAYS-2:0]   plruArr  [SETS];
  logic [WAY_W-1:0]  fillWay;

  // tag compare per way
  logic [WAYS-1:0] hitVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validArr[idx][w] && (tagMem[{idx, WAY_W'(w)}] == tag);
  end

  logic [WAY_W-1:0] hitWay;
  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end
  assign hit = |hitVec;

  // replacement
  logic [WAY_W-1:0] touchWay, plruVictim, freeWay, victimWay;
  logic [WAYS-2:0]  plruNext;
  logic             freeFound;

  assign touchWay = strobe.complete ? fillWay : hitWay;

  vc_plru #(.WAYS(WAYS)) u_plru (
    .treeIn    (plruArr[idx]),
    .touchWay  (touchWay),
    .treeOut   (plruNext),
    .victimWay (plruVictim)
  );

  always_comb begin
    freeFound = 1'b0;
    freeWay   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validArr[idx][w]) begin
        freeFound = 1'b1;
        freeWay   = WAY_W'(w);
      end
    end
  end
  assign victimWay = freeFound ? freeWay : plruVictim;

  logic [IDX_W+WAY_W-1:0] victimSlot;
  assign victimSlot  = {idx, victimWay};
  assign victimValid = validArr[idx][victimWay];
  assign victimDirty = dirtyArr[idx][victimWay];
  assign victimAddr  = {tagMem[victimSlot], idx, OFF_W'(0)};
  assign victimData  = dataMem[victimSlot];
  assign fillAddr    = {pDw[DWA_W-1:BSEL_W], OFF_W'(0)};

  // doubleword selects
  logic [SEL_W-1:0] wordSel, beatSel;
  assign wordSel  = {word, SH_W'(0)};
  assign beatSel  = {beatIdx, SH_W'(0)};
  assign critBeat = (beatIdx == word);

  logic [WAY_W-1:0] rdWay;
  assign rdWay  = strobe.touchHit ? hitWay : fillWay;
  assign rdData = dataMem[{idx, rdWay}][wordSel +: BEAT_W];

  // line state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        plruArr[s]  <= '0;
      end
      fillWay <= '0;
    end else begin
      if (strobe.allocate) begin
        validArr[idx][victimWay] <= 1'b0;
        dirtyArr[idx][victimWay] <= 1'b0;
        fillWay                  <= victimWay;
      end
      if (strobe.touchHit) begin
        plruArr[idx] <= plruNext;
        if (pWrite) dirtyArr[idx][hitWay] <= 1'b1;
      end
      if (strobe.complete) begin
        validArr[idx][fillWay] <= 1'b1;
        dirtyArr[idx][fillWay] <= pWrite;
        plruArr[idx]           <= plruNext;
      end
    end
  end

  // tags and data, no reset
  always_ff @(posedge clk) begin
    if (strobe.allocate)
      tagMem[victimSlot] <= tag;
    if (strobe.touchHit && pWrite)
      dataMem[{idx, hitWay}][wordSel +: BEAT_W] <= pWdata;
    if (strobe.beatWrite)
      dataMem[{idx, fillWay}][beatSel +: BEAT_W] <=
        (pWrite && critBeat) ? pWdata : fillBeatData;
  end

endmodule

// File: rtl/vc_control.sv
module vc_control
  import vc_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lastLevel,
  input  logic                     reqValid,
  input  logic                     hit,
  input  logic                     critBeat,
  input  logic                     victimValid,
  input  logic                     victimDirty,
  input  logic                     fillBeatValid,
  output vcStrobe_t                strobe,
  output logic [$clog2(BEATS)-1:0] beatIdx,
  output logic                     reqReady,
  output logic                     lookupValid,
  output logic                     lookupHit,
  output logic                     rspValid,
  output logic                     fillReq,
  output logic                     castValid
);
  localparam int BSEL_W = $clog2(BEATS);

  vcState_t          state;
  logic [BSEL_W-1:0] beatCnt;
  logic              respPend;
  logic              lastBeat;

  assign lastBeat = (beatCnt == BSEL_W'(BEATS - 1));
  assign beatIdx  = beatCnt;

  always_comb begin
    strobe           = '0;
    strobe.capture   = (state == ST_IDLE) && !respPend && reqValid;
    strobe.touchHit  = (state == ST_LOOKUP) && hit;
    strobe.allocate  = (state == ST_LOOKUP) && !hit;
    strobe.beatWrite = (state == ST_FILL) && fillBeatValid;
    strobe.complete  = (state == ST_FILL) && fillBeatValid && lastBeat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      beatCnt  <= '0;
      respPend <= 1'b0;
    end else begin
      respPend <= strobe.beatWrite && critBeat;
      case (state)
        ST_IDLE:   if (strobe.capture) state <= ST_LOOKUP;
        ST_LOOKUP: begin
          beatCnt <= '0;
          state   <= hit ? ST_IDLE : ST_FILL;
        end
        ST_FILL: if (fillBeatValid) begin
          beatCnt <= beatCnt + 1'b1;
          if (lastBeat) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady    = (state == ST_IDLE) && !respPend;
  assign lookupValid = (state == ST_LOOKUP);
  assign lookupHit   = (state == ST_LOOKUP) && hit;
  assign rspValid    = ((state == ST_LOOKUP) && hit) || respPend;
  assign fillReq     = strobe.allocate;
  assign castValid   = strobe.allocate && victimValid && (victimDirty || !lastLevel);

endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  parameter int BEAT_W     = 64,
  localparam int DWA_W     = ADDR_W - $clog2(BEAT_W / 8),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lastLevel,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [DWA_W-1:0]  reqDwAddr,
  input  logic [BEAT_W-1:0] reqWdata,
  output logic              lookupValid,
  output logic              lookupHit,
  output logic              rspValid,
  output logic [BEAT_W-1:0] rspData,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillBeatValid,
  input  logic [BEAT_W-1:0] fillBeatData,
  output logic              castValid,
  output logic              castDirty,
  output logic [ADDR_W-1:0] castAddr,
  output logic [LINE_W-1:0] castData
);
  localparam int BEATS  = LINE_W / BEAT_W;
  localparam int BSEL_W = $clog2(BEATS);

  vcStrobe_t         strobe;
  logic [BSEL_W-1:0] beatIdx;
  logic              hit, critBeat, victimValid, victimDirty;

  vc_control #(.BEATS(BEATS)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .lastLevel     (lastLevel),
    .reqValid      (reqValid),
    .hit           (hit),
    .critBeat      (critBeat),
    .victimValid   (victimValid),
    .victimDirty   (victimDirty),
    .fillBeatValid (fillBeatValid),
    .strobe        (strobe),
    .beatIdx       (beatIdx),
    .reqReady      (reqReady),
    .lookupValid   (lookupValid),
    .lookupHit     (lookupHit),
    .rspValid      (rspValid),
    .fillReq       (fillReq),
    .castValid     (castValid)
  );

  vc_datapath #(
    .ADDR_W     (ADDR_W),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .LINE_BYTES (LINE_BYTES),
    .BEAT_W     (BEAT_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .beatIdx      (beatIdx),
    .reqDwAddr    (reqDwAddr),
    .reqWrite     (reqWrite),
    .reqWdata     (reqWdata),
    .fillBeatData (fillBeatData),
    .hit          (hit),
    .critBeat     (critBeat),
    .victimValid  (victimValid),
    .victimDirty  (castDirty),
    .victimAddr   (castAddr),
    .victimData   (castData),
    .fillAddr     (fillAddr),
    .rdData       (rspData)
  );

  assign victimDirty = castDirty;

endmodule

// File: rtl/vc_checker.sv
module vc_checker (
  input logic clk,
  input logic rst,
  input logic lastLevel,
  input logic reqValid,
  input logic reqReady,
  input logic lookupValid,
  input logic lookupHit,
  input logic rspValid,
  input logic fillReq,
  input logic castValid,
  input logic castDirty
);

  // R2
  lookup_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    lookupValid |-> $past(reqValid && reqReady));

  // R2
  lookup_single_chk: assert property (@(posedge clk) disable iff (rst)
    lookupValid |=> !lookupValid);

  // R3
  hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (lookupValid && lookupHit) |-> rspValid);

  // R4
  miss_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (lookupValid && !lookupHit) |-> fillReq);

  // R10
  clean_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (castValid && lastLevel) |-> castDirty);

  // R10
  cast_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    castValid |-> fillReq);

  // R11
  busy_fill_chk: assert property (@(posedge clk) disable iff (rst)
    fillReq |=> !reqReady);

endmodule

bind victim_cache vc_checker u_chk (.*);

// File: tb/sim_victim_cache.sv
module sim_victim_cache;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, lastLevel, reqValid, reqReady, reqWrite;
  logic [28:0]   reqDwAddr;
  logic [63:0]   reqWdata, rspData, fillBeatData;
  logic          lookupValid, lookupHit, rspValid, fillReq, fillBeatValid;
  logic          castValid, castDirty;
  logic [31:0]   fillAddr, castAddr;
  logic [255:0]  castData;

  victim_cache u0 (
    .clk(clk), .rst(rst), .lastLevel(lastLevel),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqDwAddr(reqDwAddr), .reqWdata(reqWdata),
    .lookupValid(lookupValid), .lookupHit(lookupHit),
    .rspValid(rspValid), .rspData(rspData),
    .fillReq(fillReq), .fillAddr(fillAddr),
    .fillBeatValid(fillBeatValid), .fillBeatData(fillBeatData),
    .castValid(castValid), .castDirty(castDirty),
    .castAddr(castAddr), .castData(castData)
  );

  int nChecks = 0;
  int nFails  = 0;

  logic [63:0]  shadow [logic [31:0]];
  logic         gCast, gCastDirty;
  logic [31:0]  gCastAddr;
  logic [255:0] gCastData;

  function automatic logic [31:0] setAddr(int i);
    return 32'h0010_0040 + 32'(i) * 32'h1000;
  endfunction

  function automatic logic [63:0] beatWord(logic [31:0] line, int k);
    return {line, 32'h5A00_0000 + 32'(k)};
  endfunction

  function automatic logic [63:0] expDw(logic [31:0] byteAddr);
    logic [31:0] a;
    a = {byteAddr[31:3], 3'b000};
    if (shadow.exists(a)) return shadow[a];
    return beatWord({a[31:5], 5'b0}, int'(a[4:3]));
  endfunction

  function automatic logic [255:0] expLine(logic [31:0] line);
    logic [255:0] r;
    for (int k = 0; k < 4; k++) r[k*64 +: 64] = expDw(line + 32'(k * 8));
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request, served completely including any line fill
  task automatic access(input bit wr, input logic [31:0] addr,
                        input logic [63:0] wd, input bit expHit, input string req);
    int crit;
    logic [31:0] line;
    crit = int'(addr[4:3]);
    line = {addr[31:5], 5'b0};
    @(negedge clk);
    for (int i = 0; i < 8 && !reqReady; i++) @(negedge clk);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqDwAddr = addr[31:3];
    reqWdata  = wd;
    if (wr) shadow[{addr[31:3], 3'b000}] = wd;
    @(negedge clk);
    reqValid = 1'b0;
    reqWrite = 1'b0;
    chk("R2", "lookupValid", 256'(lookupValid), 256'(1));
    chk(req, "lookupHit", 256'(lookupHit), 256'(expHit));
    chk(req, "fillReq", 256'(fillReq), 256'(!expHit));
    gCast      = castValid;
    gCastDirty = castDirty;
    gCastAddr  = castAddr;
    gCastData  = castData;
    if (expHit) begin
      chk("R3", "rspValid on hit", 256'(rspValid), 256'(1));
      if (!wr) chk("R3", "rspData on hit", 256'(rspData), 256'(expDw(addr)));
    end else begin
      chk("R4", "fillAddr", 256'(fillAddr), 256'(line));
      @(negedge clk);
      chk("R11", "reqReady during fill", 256'(reqReady), 256'(0));
      fillBeatValid = 1'b1;
      fillBeatData  = beatWord(line, 0);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R5", "rspValid after beat", 256'(rspValid), 256'(k == crit));
        if (k == crit && !wr)
          chk("R5", "rspData after beat", 256'(rspData), 256'(expDw(addr)));
        if (k < 3) fillBeatData = beatWord(line, k + 1);
        else fillBeatValid = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1", "reqReady after reset", 256'(reqReady), 256'(1));
    chk("R1", "lookupValid idle", 256'(lookupValid), 256'(0));
    chk("R1", "rspValid idle", 256'(rspValid), 256'(0));
    chk("R1", "castValid idle", 256'(castValid), 256'(0));
  endtask

  task automatic t_readMissHit();
    access(1'b0, 32'h0000_1008, '0, 1'b0, "R1");
    chk("R1", "no castout after reset", 256'(gCast), 256'(0));
    access(1'b0, 32'h0000_1018, '0, 1'b1, "R3");
    access(1'b0, 32'h0000_1000, '0, 1'b1, "R4");
  endtask

  task automatic t_critBeat();
    access(1'b0, 32'h0000_2018, '0, 1'b0, "R5");
    access(1'b0, 32'h0000_3000, '0, 1'b0, "R5");
    access(1'b0, 32'h0000_3010, '0, 1'b1, "R4");
  endtask

  task automatic t_write();
    access(1'b1, 32'h0000_1010, 64'hDEAD_BEEF_0101_2020, 1'b1, "R6");
    access(1'b0, 32'h0000_1010, '0, 1'b1, "R6");
    access(1'b1, 32'h0000_4008, 64'hCAFE_F00D_3344_5566, 1'b0, "R6");
    access(1'b0, 32'h0000_4008, '0, 1'b1, "R6");
    access(1'b0, 32'h0000_4010, '0, 1'b1, "R6");
  endtask

  task automatic t_setFill();
    for (int i = 0; i < 8; i++) begin
      if (i == 6)
        access(1'b1, setAddr(i) + 32'(8 * (i % 4)), 64'h0BAD_C0DE_6666_0006, 1'b0, "R8");
      else
        access(1'b0, setAddr(i) + 32'(8 * (i % 4)), '0, 1'b0, "R8");
      chk("R8", "no castout while way free", 256'(gCast), 256'(0));
    end
    for (int i = 0; i < 8; i++)
      access(1'b0, setAddr(i) + 32'(8 * (i % 4)), '0, 1'b1, "R7");
  endtask

  task automatic t_plruClean();
    lastLevel = 1'b0;
    access(1'b0, setAddr(0), '0, 1'b1, "R9");
    access(1'b0, setAddr(8), '0, 1'b0, "R9");
    chk("R10", "clean castout forwarded", 256'(gCast), 256'(1));
    chk("R10", "clean castDirty", 256'(gCastDirty), 256'(0));
    chk("R9", "victim address", 256'(gCastAddr), 256'(setAddr(4)));
    chk("R10", "victim data", gCastData, expLine(setAddr(4)));
  endtask

  task automatic t_lastLevel();
    lastLevel = 1'b1;
    access(1'b0, setAddr(9) + 32'h8, '0, 1'b0, "R10");
    chk("R10", "clean victim dropped", 256'(gCast), 256'(0));
    access(1'b0, setAddr(10) + 32'h18, '0, 1'b0, "R10");
    chk("R10", "dirty castout sent", 256'(gCast), 256'(1));
    chk("R10", "dirty castDirty", 256'(gCastDirty), 256'(1));
    chk("R9", "dirty victim address", 256'(gCastAddr), 256'(setAddr(6)));
    chk("R6", "merged victim data", gCastData, expLine(setAddr(6)));
    lastLevel = 1'b0;
  endtask

  task automatic t_resetClears();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "reqReady after second reset", 256'(reqReady), 256'(1));
    access(1'b0, setAddr(0), '0, 1'b0, "R1");
    chk("R1", "no castout after reset", 256'(gCast), 256'(0));
  endtask

  initial begin
    rst = 1'b1; lastLevel = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqDwAddr = '0; reqWdata = '0; fillBeatValid = 1'b0; fillBeatData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readMissHit();
    t_critBeat();
    t_write();
    t_setFill();
    t_plruClean();
    t_lastLevel();
    t_resetClears();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule